// File: doc/BRIEF.md
# Staged Pipeline Control Propagation

This block is the control path of an in-order pipeline with five stages that every instruction passes through in the same order: fetch, decode, execute, memory and write-back. Each instruction belongs to one of four classes: register-to-register ALU operation, word load, word store and branch-on-equal. The opcode presented in decode is turned by pure combinational logic into one control bundle. The bundle is split into three groups, one for each stage that uses it. The execute group holds the destination select, the two-bit ALU operation code and the operand source select. The memory group holds the branch, read and write strobes. The write-back group holds the register-write enable and the load-result select.

The bundle moves forward one stage per clock through the decode/execute, execute/memory and memory/write-back registers. Each stage picks up its own group and does not pass it on, so each register holds only the groups still needed further down the pipeline. The two register-number fields of the instruction travel with it into execute. There the destination is chosen: the third register field for ALU operations, the second field otherwise. The chosen index then rides along with its instruction to write-back, so it never depends on what is being decoded at that time. There is no state machine. A synchronous active-high reset empties every pipeline register.

Top module: `stage_ctrl_top`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every control output and `wbDestReg` is 0.
- R2: An opcode of 0x00 (ALU class) gives, one cycle after it is in decode, `exRegDst`=1, `exAluOp`=2'b10 and `exAluSrc`=0. Two cycles after decode `memBranch`, `memRead` and `memWrite` are 0. Three cycles after decode `wbRegWrite`=1 and `wbMemToReg`=0.
- R3: Opcode 0x23 (load) gives EX {0, 2'b00, 1}, MEM {branch 0, read 1, write 0} and WB {1, 1}.
- R4: Opcode 0x2B (store) gives EX {0, 2'b00, 1}, MEM {0, 0, 1} and WB {0, 0}.
- R5: Opcode 0x04 (branch) gives EX {0, 2'b01, 0}, MEM {1, 0, 0} and WB {0, 0}.
- R6: Any other opcode gives all-zero groups in every stage, which makes it a bubble.
- R7: The EX group is visible 1 cycle after decode, the MEM group 2 cycles after and the WB group 3 cycles after. Each group belongs to the same instruction, whatever follows it in decode.
- R8: `wbDestReg` is, 3 cycles after decode, the `idRd` value decoded with an ALU-class opcode, or the `idRt` value for any other opcode.
- R9: An ALU-class instruction raises no memory strobe in MEM. A store raises no register write in WB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idOpcode | input | 6 | Opcode of the instruction in decode |
| idRt | input | 5 | Second register field of the instruction in decode |
| idRd | input | 5 | Third register field of the instruction in decode |
| exRegDst | output | 1 | EX: choose the third field as destination |
| exAluOp | output | 2 | EX: ALU operation class |
| exAluSrc | output | 1 | EX: second operand is the immediate |
| memBranch | output | 1 | MEM: branch-on-equal |
| memRead | output | 1 | MEM: data read strobe |
| memWrite | output | 1 | MEM: data write strobe |
| wbRegWrite | output | 1 | WB: register write enable |
| wbMemToReg | output | 1 | WB: write the loaded data rather than the ALU result |
| wbDestReg | output | 5 | WB: destination register index |

## Verification
The assertions assume that a new instruction, or a bubble opcode, is in decode on every cycle after reset. They also assume that the opcode and register fields are held steady across each clock edge. Properties that look back two or three cycles are gated by the reset history, so they only speak once the pipeline has refilled. The stimulus drives one instruction per cycle on the falling edge, with no idle gaps. It fills the gaps with an unsupported opcode and uses a different register pair for each instruction, so that a register field taken from the wrong instruction shows up as a wrong index.

// File: rtl/stage_ctrl_pkg.sv
package stage_ctrl_pkg;
  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
  } exGrp_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memGrp_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wbGrp_t;

  typedef struct packed {
    exGrp_t  ex;
    memGrp_t mem;
    wbGrp_t  wb;
  } ctlBundle_t;

  typedef struct packed {
    memGrp_t mem;
    wbGrp_t  wb;
  } lateBundle_t;

  // strobes from the control pipe to the destination-index datapath
  typedef struct packed {
    logic pickRd;
  } destCtl_t;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import stage_ctrl_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_RFMT = 6'h00,
  parameter logic [OPW-1:0] OP_LW   = 6'h23,
  parameter logic [OPW-1:0] OP_SW   = 6'h2B,
  parameter logic [OPW-1:0] OP_BEQ  = 6'h04
) (
  input  logic [OPW-1:0] opcode,
  output ctlBundle_t     bundle
);
  always_comb begin
    bundle = '0;
    if (opcode == OP_RFMT) begin
      bundle.ex = '{regDst: 1'b1, aluOp: 2'b10, aluSrc: 1'b0};
      bundle.wb = '{regWrite: 1'b1, memToReg: 1'b0};
    end else if (opcode == OP_LW) begin
      bundle.ex  = '{regDst: 1'b0, aluOp: 2'b00, aluSrc: 1'b1};
      bundle.mem = '{branch: 1'b0, memRead: 1'b1, memWrite: 1'b0};
      bundle.wb  = '{regWrite: 1'b1, memToReg: 1'b1};
    end else if (opcode == OP_SW) begin
      bundle.ex  = '{regDst: 1'b0, aluOp: 2'b00, aluSrc: 1'b1};
      bundle.mem = '{branch: 1'b0, memRead: 1'b0, memWrite: 1'b1};
    end else if (opcode == OP_BEQ) begin
      bundle.ex  = '{regDst: 1'b0, aluOp: 2'b01, aluSrc: 1'b0};
      bundle.mem = '{branch: 1'b1, memRead: 1'b0, memWrite: 1'b0};
    end
  end
endmodule

// File: rtl/ctl_pipe.sv
module ctl_pipe
  import stage_ctrl_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_RFMT = 6'h00,
  parameter logic [OPW-1:0] OP_LW   = 6'h23,
  parameter logic [OPW-1:0] OP_SW   = 6'h2B,
  parameter logic [OPW-1:0] OP_BEQ  = 6'h04
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] idOpcode,
  output exGrp_t         exCtl,
  output memGrp_t        memCtl,
  output wbGrp_t         wbCtl,
  output destCtl_t       destCtl
);
  ctlBundle_t  idBundle;
  ctlBundle_t  idExQ;
  lateBundle_t exMemQ;
  wbGrp_t      memWbQ;

  ctl_decode #(
    .OPW(OPW), .OP_RFMT(OP_RFMT), .OP_LW(OP_LW), .OP_SW(OP_SW), .OP_BEQ(OP_BEQ)
  ) i_decode (
    .opcode(idOpcode),
    .bundle(idBundle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idExQ  <= '0;
      exMemQ <= '0;
      memWbQ <= '0;
    end else begin
      idExQ      <= idBundle;
      exMemQ.mem <= idExQ.mem;   // EX group dropped here
      exMemQ.wb  <= idExQ.wb;
      memWbQ     <= exMemQ.wb;   // MEM group dropped here
    end
  end

  assign exCtl          = idExQ.ex;
  assign memCtl         = exMemQ.mem;
  assign wbCtl          = memWbQ;
  assign destCtl.pickRd = idExQ.ex.regDst;
endmodule

// File: rtl/dest_pipe.sv
module dest_pipe
  import stage_ctrl_pkg::*;
#(
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [REGW-1:0] idRt,
  input  logic [REGW-1:0] idRd,
  input  destCtl_t        destCtl,
  output logic [REGW-1:0] wbDest
);
  logic [REGW-1:0] exRt, exRd, exDest, memDest, wbDestQ;

  assign exDest = destCtl.pickRd ? exRd : exRt;

  always_ff @(posedge clk) begin
    if (rst) begin
      exRt    <= '0;
      exRd    <= '0;
      memDest <= '0;
      wbDestQ <= '0;
    end else begin
      exRt    <= idRt;
      exRd    <= idRd;
      memDest <= exDest;
      wbDestQ <= memDest;
    end
  end

  assign wbDest = wbDestQ;
endmodule

// File: rtl/stage_ctrl_top.sv
module stage_ctrl_top
  import stage_ctrl_pkg::*;
#(
  parameter int OPW  = 6,
  parameter int REGW = 5,
  parameter logic [OPW-1:0] OP_RFMT = 6'h00,
  parameter logic [OPW-1:0] OP_LW   = 6'h23,
  parameter logic [OPW-1:0] OP_SW   = 6'h2B,
  parameter logic [OPW-1:0] OP_BEQ  = 6'h04
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  idOpcode,
  input  logic [REGW-1:0] idRt,
  input  logic [REGW-1:0] idRd,
  output logic            exRegDst,
  output logic [1:0]      exAluOp,
  output logic            exAluSrc,
  output logic            memBranch,
  output logic            memRead,
  output logic            memWrite,
  output logic            wbRegWrite,
  output logic            wbMemToReg,
  output logic [REGW-1:0] wbDestReg
);
  exGrp_t   exCtl;
  memGrp_t  memCtl;
  wbGrp_t   wbCtl;
  destCtl_t destCtl;

  ctl_pipe #(
    .OPW(OPW), .OP_RFMT(OP_RFMT), .OP_LW(OP_LW), .OP_SW(OP_SW), .OP_BEQ(OP_BEQ)
  ) i_ctl (
    .clk(clk), .rst(rst), .idOpcode(idOpcode),
    .exCtl(exCtl), .memCtl(memCtl), .wbCtl(wbCtl), .destCtl(destCtl)
  );

  dest_pipe #(.REGW(REGW)) i_dest (
    .clk(clk), .rst(rst), .idRt(idRt), .idRd(idRd),
    .destCtl(destCtl), .wbDest(wbDestReg)
  );

  assign exRegDst   = exCtl.regDst;
  assign exAluOp    = exCtl.aluOp;
  assign exAluSrc   = exCtl.aluSrc;
  assign memBranch  = memCtl.branch;
  assign memRead    = memCtl.memRead;
  assign memWrite   = memCtl.memWrite;
  assign wbRegWrite = wbCtl.regWrite;
  assign wbMemToReg = wbCtl.memToReg;
endmodule

// File: rtl/stage_ctrl_chk.sv
module stage_ctrl_chk #(
  parameter int OPW  = 6,
  parameter int REGW = 5,
  parameter logic [OPW-1:0] OP_RFMT = 6'h00,
  parameter logic [OPW-1:0] OP_LW   = 6'h23,
  parameter logic [OPW-1:0] OP_SW   = 6'h2B
) (
  input logic            clk,
  input logic            rst,
  input logic [OPW-1:0]  idOpcode,
  input logic [REGW-1:0] idRt,
  input logic [REGW-1:0] idRd,
  input logic            exRegDst,
  input logic [1:0]      exAluOp,
  input logic            exAluSrc,
  input logic            memBranch,
  input logic            memRead,
  input logic            memWrite,
  input logic            wbRegWrite,
  input logic            wbMemToReg,
  input logic [REGW-1:0] wbDestReg
);
  logic rstQ = 1'b0;

  always_ff @(posedge clk) begin
    // R1
    if (rstQ)
      reset_clear_chk: assert ({exRegDst, exAluOp, exAluSrc, memBranch, memRead, memWrite,
                                wbRegWrite, wbMemToReg, wbDestReg} == '0);
    rstQ <= rst;
  end

  // R2
  rfmt_ex_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(idOpcode) == OP_RFMT) |-> (exRegDst && exAluOp == 2'b10 && !exAluSrc));

  // R4
  store_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(idOpcode, 2) == OP_SW) |-> (memWrite && !memRead));

  // R8
  rfmt_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past(idOpcode, 3) == OP_RFMT)
      |-> (wbRegWrite && !wbMemToReg && wbDestReg == $past(idRd, 3)));

  // R3
  load_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && $past(idOpcode, 3) == OP_LW)
      |-> (wbRegWrite && wbMemToReg && wbDestReg == $past(idRt, 3)));

  // R6
  mem_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memBranch, memRead, memWrite}));

  // R9
  store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> !wbRegWrite);
endmodule

bind stage_ctrl_top stage_ctrl_chk #(
  .OPW(OPW), .REGW(REGW), .OP_RFMT(OP_RFMT), .OP_LW(OP_LW), .OP_SW(OP_SW)
) i_chk (.*);

// File: tb/test_stage_ctrl_top.sv
module test_stage_ctrl_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] exF;    // regDst, aluOp[1:0], aluSrc
    logic [2:0] memF;   // branch, read, write
    logic [1:0] wbF;    // regWrite, memToReg
    logic [4:0] dest;
    logic [3:0] cls;    // 1..6 requirement number of the class
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] idOpcode = 6'h3F;
  logic [4:0] idRt = '0;
  logic [4:0] idRd = '0;
  logic       exRegDst, exAluSrc, memBranch, memRead, memWrite, wbRegWrite, wbMemToReg;
  logic [1:0] exAluOp;
  logic [4:0] wbDestReg;

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b0;
  item_t sbQ[$];
  item_t exI, memI, wbI;

  stage_ctrl_top i_stage_ctrl_top (
    .clk(clk), .rst(rst), .idOpcode(idOpcode), .idRt(idRt), .idRd(idRd),
    .exRegDst(exRegDst), .exAluOp(exAluOp), .exAluSrc(exAluSrc),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbRegWrite(wbRegWrite), .wbMemToReg(wbMemToReg), .wbDestReg(wbDestReg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected item from the requirement tables (R2..R6, R8)
  function automatic item_t expect_of(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rd);
    item_t e;
    e = '0;
    e.dest = rt;
    case (op)
      6'h00: begin e.exF = 4'b1100; e.wbF = 2'b10; e.dest = rd; e.cls = 4'd2; end
      6'h23: begin e.exF = 4'b0001; e.memF = 3'b010; e.wbF = 2'b11; e.cls = 4'd3; end
      6'h2B: begin e.exF = 4'b0001; e.memF = 3'b001; e.cls = 4'd4; end
      6'h04: begin e.exF = 4'b0010; e.memF = 3'b100; e.cls = 4'd5; end
      default: e.cls = 4'd6;
    endcase
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // driver: one instruction per cycle, pushed onto the scoreboard
  task automatic issue(input logic [5:0] op, input logic [4:0] rt, input logic [4:0] rd);
    @(negedge clk);
    idOpcode = op;
    idRt     = rt;
    idRd     = rd;
    sbQ.push_back(expect_of(op, rt, rd));
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: stage shadow advanced on the edge, compared away from it
  always @(posedge clk) begin
    if (rst) begin
      exI <= '{default: '0, cls: 4'd1};
      memI <= '{default: '0, cls: 4'd1};
      wbI <= '{default: '0, cls: 4'd1};
    end else begin
      memI <= exI;
      wbI  <= memI;
      if (sbQ.size() > 0) exI <= sbQ.pop_front();
      else exI <= expect_of(6'h3F, idRt, idRd);
    end
  end

  always @(negedge clk) begin
    if (running) begin
      check(tag_of(exI.cls), "EX group", {4'b0, exRegDst, exAluOp, exAluSrc}, {4'b0, exI.exF});
      // R7: MEM group two cycles after decode; R9 for the ALU class
      check({tag_of(memI.cls), memI.cls == 4'd2 ? " R9" : "", " R7"}, "MEM group",
            {5'b0, memBranch, memRead, memWrite}, {5'b0, memI.memF});
      // R7: WB group three cycles after decode; R9 for the store class
      check({tag_of(wbI.cls), wbI.cls == 4'd4 ? " R9" : "", " R7"}, "WB group",
            {6'b0, wbRegWrite, wbMemToReg}, {6'b0, wbI.wbF});
      check(wbI.cls == 4'd1 ? "R1" : "R8", "dest index", {3'b0, wbDestReg}, {3'b0, wbI.dest});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    running = 1'b1;
    rst = 1'b0;
    // add, lw, sub, sw with distinct register pairs
    issue(6'h00, 5'd2, 5'd10);
    issue(6'h23, 5'd12, 5'd7);
    issue(6'h00, 5'd1, 5'd15);
    issue(6'h2B, 5'd9, 5'd3);
    issue(6'h04, 5'd4, 5'd5);
    issue(6'h3F, 5'd6, 5'd8);
    issue(6'h01, 5'd30, 5'd29);
    // back-to-back loads and stores, then branch after ALU op
    issue(6'h23, 5'd17, 5'd18);
    issue(6'h2B, 5'd19, 5'd20);
    issue(6'h23, 5'd21, 5'd22);
    issue(6'h00, 5'd31, 5'd0);
    issue(6'h04, 5'd11, 5'd13);
    for (int k = 0; k < 6; k++) issue(6'h3F, 5'(k), 5'(k + 8));
    // reset in the middle of traffic (R1)
    issue(6'h23, 5'd25, 5'd26);
    issue(6'h00, 5'd27, 5'd28);
    do_reset(2);
    sbQ.push_back(expect_of(idOpcode, idRt, idRd));
    for (int k = 0; k < 10; k++) begin
      logic [5:0] op;
      op = (k % 4 == 0) ? 6'h00 : (k % 4 == 1) ? 6'h23 : (k % 4 == 2) ? 6'h2B : 6'h04;
      issue(op, 5'(3 * k + 1), 5'(31 - k));
    end
    for (int k = 0; k < 5; k++) issue(6'h3F, 5'd14, 5'd16);
    @(negedge clk);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule